// File: doc/BRIEF.md
# Segment Selector Loader with Shadow Descriptor Cache

This block handles a write of a 16-bit selector into one of six segment registers. It splits the selector into its fields and checks the selector first. If the selector passes, the block fetches the 8-byte descriptor from a table memory as two 32-bit reads. It then checks that the segment is present, that its type fits the target register, and that the access has enough privilege. When every check passes, the decoded descriptor goes into a hidden per-register shadow entry. Later address generation reads only that shadow entry and never goes back to memory.

The table base address and the byte limit come from a table-register input. A load either completes with a one-cycle `done` pulse or is refused with a one-cycle `fault` pulse and a fault code. A refused load leaves every shadow entry as it was. The current privilege level is shown on `cpl`. The code-segment register is reached only through the far-transfer path, marked by `load_far`.

Top module: `seg_shadow_loader`

## Requirements
- R1: Selector fields are: requested privilege RPL = bits [1:0], table-select = bit 2, index = bits [15:3]. The descriptor low word is read at `tbl_base + 8*index` and the high word at `tbl_base + 8*index + 4`. `mem_addr` holds steady while `mem_req` is high and `mem_ack` is low.
- R2: The descriptor is decoded as follows. From the low word: limit[15:0] = lo[15:0] and base[15:0] = lo[31:16]. From the high word: base[23:16] = hi[7:0], A = hi[8], RW = hi[9], DC = hi[10], X = hi[11], S = hi[12], DPL = hi[14:13], P = hi[15], limit[19:16] = hi[19:16], AVL = hi[20], L = hi[21], D = hi[22], G = hi[23], base[31:24] = hi[31:24]. Each register's 12-bit flags field is {G,D,L,AVL,P,S,X,DC,RW,A,DPL[1:0]}.
- R3: After a successful load, the target register's selector, base, limit and flags outputs show the new values and its usable bit is 1. `done` is high for exactly one cycle, and the shadow changes only at the edge that raises `done`. Register codes: 0 es, 1 cs, 2 ss, 3 ds, 4 fs, 5 gs.
- R4: A load into cs (code 1) with `load_far` = 0 faults with code 1 and makes no memory access.
- R5: A selector with table-select = 1 faults with code 2.
- R6: A selector with index 0 loaded into cs or ss faults with code 3. Loaded into es, ds, fs or gs, it completes with no memory read: the selector is stored, and base, limit and flags are zero with usable = 0.
- R7: The load faults with code 4 when `8*index + 7` exceeds `tbl_limit`. When it equals `tbl_limit`, the load proceeds.
- R8: A fetched descriptor with P = 0 faults with code 5.
- R9: The type must fit the register, or the load faults with code 6. cs needs S=1 and X=1. ss needs S=1, X=0 and RW=1. The data registers need S=1 and either X=0 or RW=1.
- R10: The load faults with code 7 when RPL > DPL or CPL > DPL. CPL is bits [1:0] of the cs selector and appears on `cpl`.
- R11: A fault pulses `fault` for one cycle with its nonzero code and changes no shadow state. `done` and `fault` are never high together. The checks run in this priority order: 1, 2, 3, 4 before any read, then 5, 6, 7.
- R12: `load_valid` is ignored while `busy` is high. The block leaves idle only on `load_valid`.
- R13: After reset, all selectors, shadow fields and usable bits are zero, `cpl` is 0, and `busy`, `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Selector write request, sampled when idle |
| load_seg | input | 3 | Target register code (0..5) |
| load_sel | input | 16 | New selector value |
| load_far | input | 1 | Request comes from the far-transfer path |
| tbl_base | input | ADDR_W | Descriptor table base address |
| tbl_limit | input | TLIM_W | Descriptor table byte limit |
| mem_req | output | 1 | Table read request |
| mem_addr | output | ADDR_W | Table read byte address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load completed (one-cycle pulse) |
| fault | output | 1 | Load refused (one-cycle pulse) |
| fault_code | output | 3 | Refusal reason, valid with `fault` |
| seg_sel_o | output | 96 | Six selectors, register k at bits [16k+15:16k] |
| seg_base_o | output | 192 | Six cached bases, 32 bits each |
| seg_limit_o | output | 120 | Six cached 20-bit raw limits |
| seg_flags_o | output | 72 | Six 12-bit flag fields |
| seg_usable_o | output | 6 | Per-register usable bit |
| cpl | output | 2 | Current privilege level |

## Verification
The properties assume several things about the inputs. `load_seg` only carries codes 0 to 5. `mem_ack` is raised only while `mem_req` is high, and `mem_rdata` is valid in that same cycle. `tbl_base` and `tbl_limit` stay still while a load is in progress. Reset is held for at least two clocks. The stimulus keeps within these assumptions: it drives only the six register codes, its table model answers only requests it sees, it changes the table limit only while the block is idle, and it can stall acknowledgements to test that the address holds steady.

// File: rtl/seg_shadow_pkg.sv
package seg_shadow_pkg;

    localparam int NUM_SEG  = 6;
    localparam int SEL_W    = 16;
    localparam int WORD_W   = 32;
    localparam int BASE_W   = 32;
    localparam int LIM_W    = 20;
    localparam int FLAG_W   = 12;
    localparam int IDX_W    = SEL_W - 3;
    localparam int SEG_ID_W = 3;

    typedef enum logic [SEG_ID_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_id_e;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_CS_DIRECT = 3'd1,
        FLT_TABLE     = 3'd2,
        FLT_NULL      = 3'd3,
        FLT_LIMIT     = 3'd4,
        FLT_ABSENT    = 3'd5,
        FLT_TYPE      = 3'd6,
        FLT_PRIV      = 3'd7
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_LO,
        ST_READ_HI,
        ST_CHECK,
        ST_DONE,
        ST_FAULT
    } fsm_e;

    // Decoded descriptor; the low FLAG_W bits form the exported flag field.
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              g;
        logic              d;
        logic              l;
        logic              avl;
        logic              p;
        logic              s;
        logic              x;
        logic              dc;
        logic              rw;
        logic              a;
        logic [1:0]        dpl;
    } desc_t;

    function automatic desc_t unpack_desc(input logic [WORD_W-1:0] lo,
                                          input logic [WORD_W-1:0] hi);
        desc_t d;
        d.base  = {hi[31:24], hi[7:0], lo[31:16]};
        d.limit = {hi[19:16], lo[15:0]};
        d.g     = hi[23];
        d.d     = hi[22];
        d.l     = hi[21];
        d.avl   = hi[20];
        d.p     = hi[15];
        d.dpl   = hi[14:13];
        d.s     = hi[12];
        d.x     = hi[11];
        d.dc    = hi[10];
        d.rw    = hi[9];
        d.a     = hi[8];
        return d;
    endfunction

    function automatic logic type_fits(input seg_id_e seg, input logic s,
                                       input logic x, input logic rw);
        logic ok;
        case (seg)
            SEG_CS:  ok = s && x;
            SEG_SS:  ok = s && !x && rw;
            default: ok = s && (!x || rw);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_shadow_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  seg_id_e           seg_i,
    input  logic              far_i,
    input  logic [TLIM_W-1:0] tbl_limit_i,
    output fault_e            fault_o,
    output logic              null_ok_o
);

    logic [IDX_W-1:0] idx;
    logic [IDX_W+2:0] last_byte;
    logic             over_limit;

    assign idx        = sel_i[SEL_W-1:3];
    assign last_byte  = {idx, 3'b111};
    assign over_limit = 32'(last_byte) > 32'(tbl_limit_i);

    // Checks that need no memory access, in fixed priority order.
    always_comb begin
        fault_o   = FLT_NONE;
        null_ok_o = 1'b0;
        if (seg_i == SEG_CS && !far_i) begin
            fault_o = FLT_CS_DIRECT;
        end else if (sel_i[2]) begin
            fault_o = FLT_TABLE;
        end else if (idx == '0) begin
            if (seg_i == SEG_CS || seg_i == SEG_SS) begin
                fault_o = FLT_NULL;
            end else begin
                null_ok_o = 1'b1;
            end
        end else if (over_limit) begin
            fault_o = FLT_LIMIT;
        end
    end

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_shadow_pkg::*;
(
    input  seg_id_e    seg_i,
    input  logic [1:0] rpl_i,
    input  logic [1:0] cpl_i,
    input  logic       p_i,
    input  logic       s_i,
    input  logic       x_i,
    input  logic       rw_i,
    input  logic [1:0] dpl_i,
    output fault_e     fault_o
);

    always_comb begin
        if (!p_i) begin
            fault_o = FLT_ABSENT;
        end else if (!type_fits(seg_i, s_i, x_i, rw_i)) begin
            fault_o = FLT_TYPE;
        end else if ((rpl_i > dpl_i) || (cpl_i > dpl_i)) begin
            fault_o = FLT_PRIV;
        end else begin
            fault_o = FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
    import seg_shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_valid_i,
    input  seg_id_e           load_seg_i,
    input  logic [SEL_W-1:0]  load_sel_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  fault_e            pre_fault_i,
    input  logic              null_ok_i,
    input  fault_e            chk_fault_i,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output fault_e            fault_code_o,
    output desc_t             desc_o,
    output seg_id_e           req_seg_o,
    output logic [1:0]        req_rpl_o,
    output logic              wr_en_o,
    output seg_id_e           wr_seg_o,
    output logic [SEL_W-1:0]  wr_sel_o,
    output logic              wr_null_o
);

    localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(WORD_W / 8);

    fsm_e              state;
    seg_id_e           seg_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    fault_e            code_q;
    logic              accept;

    assign accept = (state == ST_IDLE) && load_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            seg_q  <= SEG_ES;
            sel_q  <= '0;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            code_q <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load_valid_i) begin
                        seg_q  <= load_seg_i;
                        sel_q  <= load_sel_i;
                        addr_q <= tbl_base_i + ADDR_W'({load_sel_i[SEL_W-1:3], 3'b000});
                        if (pre_fault_i != FLT_NONE) begin
                            code_q <= pre_fault_i;
                            state  <= ST_FAULT;
                        end else if (null_ok_i) begin
                            state  <= ST_DONE;
                        end else begin
                            state  <= ST_READ_LO;
                        end
                    end
                end
                ST_READ_LO: begin
                    if (mem_ack_i) begin
                        lo_q  <= mem_rdata_i;
                        state <= ST_READ_HI;
                    end
                end
                ST_READ_HI: begin
                    if (mem_ack_i) begin
                        hi_q  <= mem_rdata_i;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (chk_fault_i != FLT_NONE) begin
                        code_q <= chk_fault_i;
                        state  <= ST_FAULT;
                    end else begin
                        state  <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_o    = (state == ST_READ_LO) || (state == ST_READ_HI);
    assign mem_addr_o   = (state == ST_READ_HI) ? addr_q + HI_OFS : addr_q;
    assign busy_o       = (state != ST_IDLE);
    assign done_o       = (state == ST_DONE);
    assign fault_o      = (state == ST_FAULT);
    assign fault_code_o = (state == ST_FAULT) ? code_q : FLT_NONE;
    assign desc_o       = unpack_desc(lo_q, hi_q);
    assign req_seg_o    = seg_q;
    assign req_rpl_o    = sel_q[1:0];

    // Shadow write: checked descriptor, or a null selector into a data register.
    assign wr_en_o   = ((state == ST_CHECK) && (chk_fault_i == FLT_NONE)) ||
                       (accept && (pre_fault_i == FLT_NONE) && null_ok_i);
    assign wr_null_o = (state == ST_IDLE);
    assign wr_seg_o  = (state == ST_IDLE) ? load_seg_i : seg_q;
    assign wr_sel_o  = (state == ST_IDLE) ? load_sel_i : sel_q;

endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank
    import seg_shadow_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  seg_id_e                   wr_seg_i,
    input  logic [SEL_W-1:0]          wr_sel_i,
    input  logic                      wr_null_i,
    input  desc_t                     wr_desc_i,
    output logic [NUM_SEG*SEL_W-1:0]  sel_o,
    output logic [NUM_SEG*BASE_W-1:0] base_o,
    output logic [NUM_SEG*LIM_W-1:0]  limit_o,
    output logic [NUM_SEG*FLAG_W-1:0] flags_o,
    output logic [NUM_SEG-1:0]        usable_o
);

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        logic [SEL_W-1:0] sel_q;
        desc_t            desc_q;
        logic             use_q;
        logic             hit;

        assign hit = wr_en_i && (wr_seg_i == seg_id_e'(SEG_ID_W'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q  <= '0;
                desc_q <= '0;
                use_q  <= 1'b0;
            end else if (hit) begin
                sel_q  <= wr_sel_i;
                desc_q <= wr_null_i ? desc_t'('0) : wr_desc_i;
                use_q  <= !wr_null_i;
            end
        end

        assign sel_o[i*SEL_W +: SEL_W]    = sel_q;
        assign base_o[i*BASE_W +: BASE_W] = desc_q.base;
        assign limit_o[i*LIM_W +: LIM_W]  = desc_q.limit;
        assign flags_o[i*FLAG_W +: FLAG_W] = desc_q[FLAG_W-1:0];
        assign usable_o[i]                = use_q;
    end

endmodule

// File: rtl/seg_shadow_loader.sv
module seg_shadow_loader
    import seg_shadow_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     load_valid,
    input  logic [2:0]                               load_seg,
    input  logic [15:0]                              load_sel,
    input  logic                                     load_far,
    input  logic [ADDR_W-1:0]                        tbl_base,
    input  logic [TLIM_W-1:0]                        tbl_limit,
    output logic                                     mem_req,
    output logic [ADDR_W-1:0]                        mem_addr,
    input  logic                                     mem_ack,
    input  logic [31:0]                              mem_rdata,
    output logic                                     busy,
    output logic                                     done,
    output logic                                     fault,
    output logic [2:0]                               fault_code,
    output logic [seg_shadow_pkg::NUM_SEG*16-1:0]    seg_sel_o,
    output logic [seg_shadow_pkg::NUM_SEG*32-1:0]    seg_base_o,
    output logic [seg_shadow_pkg::NUM_SEG*20-1:0]    seg_limit_o,
    output logic [seg_shadow_pkg::NUM_SEG*12-1:0]    seg_flags_o,
    output logic [seg_shadow_pkg::NUM_SEG-1:0]       seg_usable_o,
    output logic [1:0]                               cpl
);

    seg_id_e          in_seg;
    fault_e           pre_fault;
    logic             null_ok;
    fault_e           chk_fault;
    fault_e           code_e;
    desc_t            desc;
    seg_id_e          req_seg;
    logic [1:0]       req_rpl;
    logic             wr_en;
    seg_id_e          wr_seg;
    logic [SEL_W-1:0] wr_sel;
    logic             wr_null;

    assign in_seg     = seg_id_e'(load_seg);
    assign fault_code = code_e;
    assign cpl        = seg_sel_o[SEG_CS*SEL_W +: 2];

    seg_sel_decode #(.TLIM_W(TLIM_W)) u_decode (
        .sel_i       (load_sel),
        .seg_i       (in_seg),
        .far_i       (load_far),
        .tbl_limit_i (tbl_limit),
        .fault_o     (pre_fault),
        .null_ok_o   (null_ok)
    );

    seg_fetch_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .load_valid_i (load_valid),
        .load_seg_i   (in_seg),
        .load_sel_i   (load_sel),
        .tbl_base_i   (tbl_base),
        .pre_fault_i  (pre_fault),
        .null_ok_i    (null_ok),
        .chk_fault_i  (chk_fault),
        .mem_ack_i    (mem_ack),
        .mem_rdata_i  (mem_rdata),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .busy_o       (busy),
        .done_o       (done),
        .fault_o      (fault),
        .fault_code_o (code_e),
        .desc_o       (desc),
        .req_seg_o    (req_seg),
        .req_rpl_o    (req_rpl),
        .wr_en_o      (wr_en),
        .wr_seg_o     (wr_seg),
        .wr_sel_o     (wr_sel),
        .wr_null_o    (wr_null)
    );

    seg_desc_check u_check (
        .seg_i   (req_seg),
        .rpl_i   (req_rpl),
        .cpl_i   (cpl),
        .p_i     (desc.p),
        .s_i     (desc.s),
        .x_i     (desc.x),
        .rw_i    (desc.rw),
        .dpl_i   (desc.dpl),
        .fault_o (chk_fault)
    );

    seg_shadow_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_seg_i  (wr_seg),
        .wr_sel_i  (wr_sel),
        .wr_null_i (wr_null),
        .wr_desc_i (desc),
        .sel_o     (seg_sel_o),
        .base_o    (seg_base_o),
        .limit_o   (seg_limit_o),
        .flags_o   (seg_flags_o),
        .usable_o  (seg_usable_o)
    );

endmodule

// File: rtl/seg_shadow_loader_sva.sv
module seg_shadow_loader_sva #(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              load_valid,
    input logic [2:0]        load_seg,
    input logic [15:0]       load_sel,
    input logic              load_far,
    input logic [ADDR_W-1:0] tbl_base,
    input logic [TLIM_W-1:0] tbl_limit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [31:0]       mem_rdata,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [2:0]        fault_code,
    input logic [95:0]       seg_sel_o,
    input logic [191:0]      seg_base_o,
    input logic [119:0]      seg_limit_o,
    input logic [71:0]       seg_flags_o,
    input logic [5:0]        seg_usable_o,
    input logic [1:0]        cpl
);

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_req_in_load_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy && !done && !fault);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_shadow_moves_on_done_R3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(seg_sel_o) || !$stable(seg_usable_o) || !$stable(seg_base_o)) |-> done);

    assert_cs_direct_R4: assert property (@(posedge clk) disable iff (rst)
        load_valid && !busy && load_seg == 3'd1 && !load_far |=> fault && fault_code == 3'd1);

    assert_table_bit_R5: assert property (@(posedge clk) disable iff (rst)
        load_valid && !busy && load_sel[2] && !(load_seg == 3'd1 && !load_far)
        |=> fault && fault_code == 3'd2);

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    assert_fault_keeps_R11: assert property (@(posedge clk) disable iff (rst)
        fault |-> fault_code != 3'd0 && $stable(seg_sel_o) && $stable(seg_flags_o)
                  && $stable(seg_limit_o) && $stable(seg_usable_o));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (rst)
        !busy && !load_valid |=> !busy);

endmodule

bind seg_shadow_loader seg_shadow_loader_sva #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_sva (.*);

// File: tb/seg_shadow_loader_bench.sv
module seg_shadow_loader_bench;

    localparam int          ADDR_W = 32;
    localparam int          TLIM_W = 16;
    localparam logic [31:0] TBASE  = 32'h0000_1000;

    // {hi, lo} per table entry
    localparam logic [63:0] DTAB [8] = '{
        64'h00000000_00000000,
        64'h12CF9A34_5678FFFF,
        64'h004092AB_CDEFFFFF,
        64'h0040F200_00001234,
        64'h00CFFA40_0000FFFF,
        64'h00401200_0000FFFF,
        64'h00409000_0000FFFF,
        64'h7735B266_55440042
    };

    typedef struct packed {
        logic [2:0]  seg;
        logic [15:0] sel;
        logic        far;
        logic [2:0]  code;
        logic [31:0] base;
        logic [19:0] lim;
        logic [11:0] flg;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 16'h0010, 1'b0, 3'd0, 32'h00ABCDEF, 20'h0FFFF, 12'h4C8},
        '{3'd0, 16'h001B, 1'b0, 3'd0, 32'h00000000, 20'h01234, 12'h4CB},
        '{3'd3, 16'h0012, 1'b0, 3'd7, 32'h0, 20'h0, 12'h0},
        '{3'd4, 16'h0028, 1'b0, 3'd5, 32'h0, 20'h0, 12'h0},
        '{3'd2, 16'h0030, 1'b0, 3'd6, 32'h0, 20'h0, 12'h0},
        '{3'd2, 16'h0010, 1'b0, 3'd0, 32'h00ABCDEF, 20'h0FFFF, 12'h4C8},
        '{3'd5, 16'h0039, 1'b0, 3'd0, 32'h77665544, 20'h50042, 12'h3C9},
        '{3'd1, 16'h0008, 1'b0, 3'd1, 32'h0, 20'h0, 12'h0},
        '{3'd1, 16'h0008, 1'b1, 3'd0, 32'h12345678, 20'hFFFFF, 12'hCE8},
        '{3'd3, 16'h0014, 1'b0, 3'd2, 32'h0, 20'h0, 12'h0},
        '{3'd2, 16'h0000, 1'b0, 3'd3, 32'h0, 20'h0, 12'h0},
        '{3'd0, 16'h0003, 1'b0, 3'd0, 32'h0, 20'h0, 12'h0},
        '{3'd3, 16'h0040, 1'b0, 3'd4, 32'h0, 20'h0, 12'h0},
        '{3'd1, 16'h0023, 1'b1, 3'd0, 32'h00400000, 20'hFFFFF, 12'hCEB},
        '{3'd3, 16'h0010, 1'b0, 3'd7, 32'h0, 20'h0, 12'h0},
        '{3'd1, 16'h0018, 1'b1, 3'd6, 32'h0, 20'h0, 12'h0},
        '{3'd3, 16'h001B, 1'b0, 3'd0, 32'h00000000, 20'h01234, 12'h4CB}
    };

    logic              clk;
    logic              rst;
    logic              load_valid;
    logic [2:0]        load_seg;
    logic [15:0]       load_sel;
    logic              load_far;
    logic [ADDR_W-1:0] tbl_base;
    logic [TLIM_W-1:0] tbl_limit;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack;
    logic [31:0]       mem_rdata;
    logic              busy;
    logic              done;
    logic              fault;
    logic [2:0]        fault_code;
    logic [95:0]       seg_sel_o;
    logic [191:0]      seg_base_o;
    logic [119:0]      seg_limit_o;
    logic [71:0]       seg_flags_o;
    logic [5:0]        seg_usable_o;
    logic [1:0]        cpl;

    logic              stall;
    logic [31:0]       moff;
    int                rd_count;
    logic [31:0]       lo_addr;
    logic [31:0]       hi_addr;

    int checks;
    int errors;

    logic [15:0] exp_sel [6];
    logic [31:0] exp_base [6];
    logic [19:0] exp_lim [6];
    logic [11:0] exp_flg [6];
    logic        exp_use [6];

    seg_shadow_loader #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_seg_shadow_loader (.*);

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Table memory model: answers requests in the same cycle unless stalled.
    assign moff      = mem_addr - TBASE;
    assign mem_ack   = mem_req && !stall;
    assign mem_rdata = (moff < 32'd64) ?
                       (moff[2] ? DTAB[moff[5:3]][63:32] : DTAB[moff[5:3]][31:0]) : 32'h0;

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            rd_count <= rd_count + 1;
            if (mem_addr[2]) hi_addr <= mem_addr;
            else             lo_addr <= mem_addr;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 6; i++) begin
            check(req, $sformatf("sel[%0d]", i), 64'(seg_sel_o[i*16 +: 16]), 64'(exp_sel[i]));
            check("R2", $sformatf("base[%0d]", i), 64'(seg_base_o[i*32 +: 32]), 64'(exp_base[i]));
            check("R2", $sformatf("limit[%0d]", i), 64'(seg_limit_o[i*20 +: 20]), 64'(exp_lim[i]));
            check("R2", $sformatf("flags[%0d]", i), 64'(seg_flags_o[i*12 +: 12]), 64'(exp_flg[i]));
            check(req, $sformatf("usable[%0d]", i), 64'(seg_usable_o[i]), 64'(exp_use[i]));
        end
        check("R10", "cpl", 64'(cpl), 64'(exp_sel[1][1:0]));
    endtask

    task automatic do_load(input logic [2:0] s, input logic [15:0] sl, input logic f,
                           output logic gd, output logic gf, output logic [2:0] gc);
        @(negedge clk);
        load_seg   = s;
        load_sel   = sl;
        load_far   = f;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        gd = 1'b0;
        gf = 1'b0;
        gc = 3'd0;
        for (int k = 0; k < 40; k++) begin
            if (done || fault) begin
                gd = done;
                gf = fault;
                gc = fault_code;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            3'd7: return "R10";
            default: return "R3";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       gd;
        logic       gf;
        logic [2:0] gc;
        int         rc;
        checks     = 0;
        errors     = 0;
        rst        = 1'b1;
        stall      = 1'b0;
        load_valid = 1'b0;
        load_seg   = 3'd0;
        load_sel   = 16'h0;
        load_far   = 1'b0;
        tbl_base   = TBASE;
        tbl_limit  = 16'd63;
        rd_count   = 0;
        lo_addr    = 32'h0;
        hi_addr    = 32'h0;
        for (int i = 0; i < 6; i++) begin
            exp_sel[i]  = 16'h0;
            exp_base[i] = 32'h0;
            exp_lim[i]  = 20'h0;
            exp_flg[i]  = 12'h0;
            exp_use[i]  = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13: reset state
        check("R13", "busy", 64'(busy), 64'd0);
        check("R13", "done", 64'(done), 64'd0);
        check("R13", "fault", 64'(fault), 64'd0);
        check("R13", "mem_req", 64'(mem_req), 64'd0);
        check_all("R13");

        // Vector walk; vector 6 reads entry 7 whose last byte equals the limit (R7 pass side)
        for (int v = 0; v < NV; v++) begin
            do_load(VECS[v].seg, VECS[v].sel, VECS[v].far, gd, gf, gc);
            check(req_of(VECS[v].code), $sformatf("vec%0d outcome", v),
                  64'({gd, gf, (gf ? gc : 3'd0)}),
                  64'({VECS[v].code == 3'd0, VECS[v].code != 3'd0, VECS[v].code}));
            if (VECS[v].code == 3'd0) begin
                exp_sel[VECS[v].seg]  = VECS[v].sel;
                exp_use[VECS[v].seg]  = (VECS[v].sel[15:3] != 13'd0);
                exp_base[VECS[v].seg] = VECS[v].base;
                exp_lim[VECS[v].seg]  = VECS[v].lim;
                exp_flg[VECS[v].seg]  = VECS[v].flg;
            end
            check_all(VECS[v].code == 3'd0 ? "R3" : "R11");
        end

        // R6: null selector into fs completes without any table read
        rc = rd_count;
        do_load(3'd4, 16'h0000, 1'b0, gd, gf, gc);
        check("R6", "null fs done", 64'({gd, gf}), 64'b10);
        check("R6", "null fs reads", 64'(rd_count - rc), 64'd0);
        exp_sel[4] = 16'h0; exp_use[4] = 1'b0;
        exp_base[4] = 32'h0; exp_lim[4] = 20'h0; exp_flg[4] = 12'h0;
        check_all("R6");

        // R7: last byte one past the limit
        @(negedge clk);
        tbl_limit = 16'd62;
        do_load(3'd5, 16'h0039, 1'b0, gd, gf, gc);
        check("R7", "limit fault", 64'({gd, gf, gc}), 64'({1'b0, 1'b1, 3'd4}));
        check_all("R11");
        @(negedge clk);
        tbl_limit = 16'd63;

        // R1 and R12: stalled fetch, held address, second request ignored
        @(negedge clk);
        stall      = 1'b1;
        load_seg   = 3'd3;
        load_sel   = 16'h001B;
        load_far   = 1'b0;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        @(negedge clk);
        check("R1", "stalled req", 64'(mem_req), 64'd1);
        check("R1", "low word addr", 64'(mem_addr), 64'(TBASE + 32'h18));
        load_seg   = 3'd5;
        load_sel   = 16'h0000;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        check("R1", "addr held", 64'(mem_addr), 64'(TBASE + 32'h18));
        stall = 1'b0;
        gd = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (done) begin gd = 1'b1; break; end
            @(negedge clk);
        end
        check("R12", "first load done", 64'(gd), 64'd1);
        check("R1", "lo read addr", 64'(lo_addr), 64'(TBASE + 32'h18));
        check("R1", "hi read addr", 64'(hi_addr), 64'(TBASE + 32'h1C));
        repeat (3) @(negedge clk);
        check("R12", "idle after", 64'(busy), 64'd0);
        check_all("R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule